// File: doc/BRIEF.md
# Extended-Data-Out DRAM Pin-Level Emulator

This block is a clocked, synthesizable stand-in for an extended-data-out DRAM device, seen from its pins. On every clock edge it samples the active-low row strobe, column strobe, write enable and output enable, together with a multiplexed address bus. It keeps the data in a small internal cell array. The data bus is driven with a separate enable, so a surrounding bench can observe when the outputs are in high impedance.

The row address is taken on the falling row strobe and the column address on each falling column strobe, which gives page-mode accesses. Reads, early writes, late writes and read-modify-write sequences are all supported. Read data stays on the bus after the column strobe rises. Output-enable and write-enable pulses turn the bus off in the ways a real device does. The output turn-off delay is a parameter counted in clock cycles.

Top module: `edo_dram_emu`

## Requirements
- R1: A column-strobe fall that is sampled with the row strobe low and write enable high starts a read of the word at the latched row and column. From the end of that edge, `dq_o` holds the stored word, and `dq_oe_o` is high whenever `oe_ni` is low.
- R2: After the column strobe returns high, the read word stays driven, unchanged, as long as the row strobe and output enable both remain low.
- R3: `dq_oe_o` is never high while `oe_ni` is high. If output enable pulses high while both strobes are low, the bus goes off and then comes back with the same word.
- R4: An edge that samples output enable high with the column strobe high and the row strobe low turns the output off. The output stays off after output enable returns low, until the next read.
- R5: An edge that samples write enable low with the column strobe high and the row strobe low turns the output off.
- R6: Early write: when write enable is already low at the column-strobe fall, `dq_i` sampled at that edge is written, and the output stays off whatever the level of `oe_ni`.
- R7: Late write or read-modify-write: a write-enable fall that comes after the column-strobe fall in the same cycle, sampled with output enable high, writes `dq_i` sampled at that edge, and the output stays off.
- R8: A late write attempted with output enable low writes nothing. The bus keeps driving the read word of the addressed location.
- R9: Once the row and column strobes have both been sampled high on T_OFF consecutive edges, the output is off whatever the level of output enable. Before that it is still driven.
- R10: The row is taken from the low ROW_W bits of `addr_i` at the row-strobe fall, and the column from the low COL_W bits at each column-strobe fall. Several columns can be accessed within one row-strobe low period.
- R11: While reset is active and right after it, `dq_oe_o` is low.
- R12: A row-strobe fall sampled with the column strobe high turns off any output still held from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Multiplexed row/column address |
| dq_i | input | DW | Write data |
| dq_o | output | DW | Read data |
| dq_oe_o | output | 1 | High when the data bus is driven |

## Verification
Every strobe level is sampled at a rising clock edge. Reads and output turn-offs therefore show up right after the edge that samples the causing level. The only exception is turn-off after both strobes rise, which lands after the T_OFF-th such edge. `dq_oe_o` also follows `oe_ni` combinationally. The bench changes pins 5 ns after a rising edge and checks outputs after the next edge, before it drives anything new. For the turn-off delay it checks both the edge before the limit (still driven) and the edge at the limit (off).

// File: rtl/edo_pkg.sv
package edo_pkg;
  localparam int NPIN    = 4;
  localparam int PIN_RAS = 0;
  localparam int PIN_CAS = 1;
  localparam int PIN_WE  = 2;
  localparam int PIN_OE  = 3;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;
endpackage

// File: rtl/edo_pin_edge.sv
module edo_pin_edge #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b1;   // strobes idle high
      else         prev_q <= pin_i[g];
    end
    assign fall_o[g] = prev_q & ~pin_i[g];
  end
endmodule

// File: rtl/edo_cell_array.sv
module edo_cell_array #(
  parameter int ROW_W = 3,
  parameter int COL_W = 3,
  parameter int DW    = 8
) (
  input  logic             clk_i,
  input  logic             wr_en_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic [DW-1:0]    rd_data_o
);
  localparam int DEPTH = 1 << (ROW_W + COL_W);

  logic [DW-1:0] mem_q [DEPTH];
  logic [ROW_W+COL_W-1:0] idx;

  assign idx = {row_i, col_i};

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[idx] <= wr_data_i;
  end

  assign rd_data_o = mem_q[idx];
endmodule

// File: rtl/edo_out_ctrl.sv
module edo_out_ctrl #(
  parameter int DW    = 8,
  parameter int T_OFF = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ras_ni,
  input  logic          cas_ni,
  input  logic          we_ni,
  input  logic          oe_ni,
  input  logic          ras_fall_i,
  input  logic          load_i,
  input  logic          wr_kill_i,
  input  logic [DW-1:0] rd_word_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o
);
  localparam int CW = $clog2(T_OFF + 1);

  logic          live_q;
  logic [DW-1:0] data_q;
  logic [CW-1:0] off_cnt_q;
  logic          both_hi, expire, page_kill;

  assign both_hi   = ras_ni & cas_ni;
  assign expire    = both_hi & (off_cnt_q == CW'(T_OFF - 1));
  // OE or WE activity during column precharge drops the held word
  assign page_kill = ~ras_ni & cas_ni & (oe_ni | ~we_ni);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           off_cnt_q <= '0;
    else if (!both_hi)     off_cnt_q <= '0;
    else if (off_cnt_q != CW'(T_OFF)) off_cnt_q <= off_cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= 1'b0;
      data_q <= '0;
    end else if (load_i) begin
      live_q <= 1'b1;
      data_q <= rd_word_i;
    end else if (wr_kill_i | ras_fall_i | page_kill | expire) begin
      live_q <= 1'b0;
    end
  end

  assign dq_o    = data_q;
  assign dq_oe_o = live_q & ~oe_ni;
endmodule

// File: rtl/edo_dram_emu.sv
module edo_dram_emu
  import edo_pkg::*;
#(
  parameter int ROW_W = 3,
  parameter int COL_W = 3,
  parameter int DW    = 8,
  parameter int T_OFF = 2,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     dq_i,
  output logic [DW-1:0]     dq_o,
  output logic              dq_oe_o
);
  logic [NPIN-1:0] pins, fall;
  logic            ras_fall, cas_fall, we_fall;
  logic            early_wr, rd_load, late_try, late_wr, wr_en;
  logic [ROW_W-1:0] row_q, row_use;
  logic [COL_W-1:0] col_q, col_use;
  logic [DW-1:0]    rd_word;
  acc_e             acc_q;

  assign pins[PIN_RAS] = ras_ni;
  assign pins[PIN_CAS] = cas_ni;
  assign pins[PIN_WE]  = we_ni;
  assign pins[PIN_OE]  = oe_ni;

  edo_pin_edge #(.N(NPIN)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pins),
    .fall_o (fall)
  );

  assign ras_fall = fall[PIN_RAS];
  assign cas_fall = fall[PIN_CAS] & ~ras_ni;
  assign we_fall  = fall[PIN_WE];

  assign row_use = ras_fall ? addr_i[ROW_W-1:0] : row_q;
  assign col_use = cas_fall ? addr_i[COL_W-1:0] : col_q;

  assign early_wr = cas_fall & ~we_ni;
  assign rd_load  = cas_fall & we_ni;
  // WE falling after the column strobe: write only with outputs disabled
  assign late_try = we_fall & ~ras_ni & ~cas_ni & ~cas_fall & (acc_q == ACC_READ);
  assign late_wr  = late_try & oe_ni;
  assign wr_en    = early_wr | late_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      col_q <= '0;
      acc_q <= ACC_IDLE;
    end else begin
      row_q <= row_use;
      col_q <= col_use;
      if (early_wr)              acc_q <= ACC_WRITE;
      else if (rd_load)          acc_q <= ACC_READ;
      else if (late_wr)          acc_q <= ACC_WRITE;
      else if (ras_ni | cas_ni)  acc_q <= ACC_IDLE;
    end
  end

  edo_cell_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DW(DW)) u_cells (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en),
    .row_i     (row_use),
    .col_i     (col_use),
    .wr_data_i (dq_i),
    .rd_data_o (rd_word)
  );

  edo_out_ctrl #(.DW(DW), .T_OFF(T_OFF)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ras_ni     (ras_ni),
    .cas_ni     (cas_ni),
    .we_ni      (we_ni),
    .oe_ni      (oe_ni),
    .ras_fall_i (ras_fall),
    .load_i     (rd_load),
    .wr_kill_i  (wr_en),
    .rd_word_i  (rd_word),
    .dq_o       (dq_o),
    .dq_oe_o    (dq_oe_o)
  );
endmodule

// File: rtl/edo_dram_emu_chk.sv
module edo_dram_emu_chk #(
  parameter int T_OFF = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ras_ni,
  input logic cas_ni,
  input logic we_ni,
  input logic oe_ni,
  input logic dq_oe_o
);
  logic [15:0] hi_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 hi_cnt_q <= '0;
    else if (!(ras_ni && cas_ni)) hi_cnt_q <= '0;
    else if (hi_cnt_q != 16'hffff) hi_cnt_q <= hi_cnt_q + 16'd1;
  end

  assert_oe_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> !oe_ni);

  assert_oe_precharge_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_ni && cas_ni && oe_ni) |=> !dq_oe_o);

  assert_we_precharge_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_ni && cas_ni && !we_ni) |=> !dq_oe_o);

  assert_early_write_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_ni && $fell(cas_ni) && !we_ni) |=> !dq_oe_o);

  assert_toff_limit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_cnt_q >= 16'(T_OFF)) |-> !dq_oe_o);

  assert_ras_fall_off_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_ni) && cas_ni) |=> !dq_oe_o);
endmodule

bind edo_dram_emu edo_dram_emu_chk #(.T_OFF(T_OFF)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ras_ni  (ras_ni),
  .cas_ni  (cas_ni),
  .we_ni   (we_ni),
  .oe_ni   (oe_ni),
  .dq_oe_o (dq_oe_o)
);

// File: tb/edo_dram_emu_tb.sv
module edo_dram_emu_tb;
  localparam int ROW_W = 3;
  localparam int COL_W = 3;
  localparam int DW    = 8;
  localparam int T_OFF = 2;
  localparam int AW    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dq_oe;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  edo_dram_emu #(.ROW_W(ROW_W), .COL_W(COL_W), .DW(DW), .T_OFF(T_OFF)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .we_ni(we_n), .oe_ni(oe_n), .addr_i(addr), .dq_i(din),
    .dq_o(dout), .dq_oe_o(dq_oe)
  );

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ras_n = 1; cas_n = 1; we_n = 1; oe_n = 1;
    repeat (T_OFF + 2) tick();
  endtask

  task automatic early_write(input int row, input int col, input logic [DW-1:0] d);
    ras_n = 0; addr = AW'(row); tick();
    cas_n = 0; we_n = 0; oe_n = 0; addr = AW'(col); din = d; tick();
    chk("R6 early write output off", {31'd0, dq_oe}, 0);
    cas_n = 1; we_n = 1; tick();
    idle();
  endtask

  // read, EDO hold, then tOFF after both strobes high (R1 R2 R9 R10)
  task automatic read_check(input int row, input int col, input logic [DW-1:0] exp);
    ras_n = 0; oe_n = 0; addr = AW'(row); tick();
    cas_n = 0; we_n = 1; addr = AW'(col); tick();
    chk("R1 oe", {31'd0, dq_oe}, 1);
    chk("R1 R10 data", {24'd0, dout}, {24'd0, exp});
    cas_n = 1; tick();
    chk("R2 hold oe", {31'd0, dq_oe}, 1);
    chk("R2 hold data", {24'd0, dout}, {24'd0, exp});
    ras_n = 1; tick();
    chk("R9 before limit", {31'd0, dq_oe}, 1);
    tick();
    chk("R9 at limit", {31'd0, dq_oe}, 0);
    idle();
  endtask

  task automatic t_reset();
    chk("R11 in reset", {31'd0, dq_oe}, 0);
    rst_n = 1; tick();
    chk("R11 after reset", {31'd0, dq_oe}, 0);
  endtask

  task automatic t_page();
    ras_n = 0; oe_n = 0; addr = 3'd1; tick();
    cas_n = 0; addr = 3'd2; tick();
    chk("R10 page col a", {24'd0, dout}, 32'hA5);
    cas_n = 1; tick();
    cas_n = 0; addr = 3'd5; tick();
    chk("R10 page col b", {24'd0, dout}, 32'h3C);
    chk("R10 page oe", {31'd0, dq_oe}, 1);
    cas_n = 1; tick();
    idle();
  endtask

  task automatic t_oe_pulse();
    ras_n = 0; oe_n = 0; addr = 3'd6; tick();
    cas_n = 0; addr = 3'd0; tick();
    oe_n = 1; tick();
    chk("R3 off while oe high", {31'd0, dq_oe}, 0);
    oe_n = 0; tick();
    chk("R3 back on", {31'd0, dq_oe}, 1);
    chk("R3 same data", {24'd0, dout}, 32'hF0);
    cas_n = 1; tick();
    idle();
  endtask

  task automatic t_oe_precharge();
    ras_n = 0; oe_n = 0; addr = 3'd0; tick();
    cas_n = 0; addr = 3'd7; tick();
    cas_n = 1; tick();
    chk("R4 held before toggle", {31'd0, dq_oe}, 1);
    oe_n = 1; tick();
    oe_n = 0; tick();
    chk("R4 stays off", {31'd0, dq_oe}, 0);
    idle();
  endtask

  task automatic t_we_precharge();
    ras_n = 0; oe_n = 0; addr = 3'd0; tick();
    cas_n = 0; addr = 3'd7; tick();
    cas_n = 1; tick();
    we_n = 0; tick();
    chk("R5 we pulse off", {31'd0, dq_oe}, 0);
    we_n = 1; tick();
    chk("R5 stays off", {31'd0, dq_oe}, 0);
    idle();
  endtask

  task automatic t_late_write();
    ras_n = 0; oe_n = 1; addr = 3'd6; tick();
    cas_n = 0; we_n = 1; addr = 3'd2; tick();
    din = 8'h77; we_n = 0; tick();
    chk("R7 late write off", {31'd0, dq_oe}, 0);
    oe_n = 0; tick();
    chk("R7 off after write", {31'd0, dq_oe}, 0);
    cas_n = 1; we_n = 1; tick();
    idle();
    read_check(6, 2, 8'h77);
  endtask

  task automatic t_late_blocked();
    ras_n = 0; oe_n = 0; addr = 3'd1; tick();
    cas_n = 0; we_n = 1; addr = 3'd5; tick();
    din = 8'hEE; we_n = 0; tick();
    chk("R8 still driven", {31'd0, dq_oe}, 1);
    chk("R8 read word", {24'd0, dout}, 32'h3C);
    cas_n = 1; we_n = 1; tick();
    idle();
    read_check(1, 5, 8'h3C);
  endtask

  task automatic t_ras_fall();
    ras_n = 0; oe_n = 0; addr = 3'd1; tick();
    cas_n = 0; addr = 3'd2; tick();
    cas_n = 1; tick();
    ras_n = 1; tick();
    chk("R12 still held", {31'd0, dq_oe}, 1);
    ras_n = 0; tick();
    chk("R12 new row off", {31'd0, dq_oe}, 0);
    idle();
  endtask

  initial begin
    repeat (3) tick();
    t_reset();
    early_write(1, 2, 8'hA5);
    early_write(1, 5, 8'h3C);
    early_write(6, 0, 8'hF0);
    early_write(0, 7, 8'h81);
    early_write(6, 2, 8'h5A);
    read_check(1, 2, 8'hA5);
    read_check(6, 2, 8'h5A);
    read_check(0, 7, 8'h81);
    t_page();
    t_oe_pulse();
    t_oe_precharge();
    t_we_precharge();
    t_late_write();
    t_late_blocked();
    t_ras_fall();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule